// File: doc/BRIEF.md
# Oscillator Fault Monitor with Non-Maskable Interrupt

This block watches a primary crystal oscillator and, when the build includes one, a secondary oscillator. Each raw oscillator clock passes through a short synchroniser into the system clock domain. An edge detector with a timeout counter then decides whether that oscillator is running. The block holds the oscillator configuration bits: high-frequency mode and the off switch for the primary, and the enable for the secondary. From those bits and the activity result it forms a fault condition. The condition sets a sticky flag that software can read and clear.

The fault flag, combined with an interrupt enable bit, drives a level-sensitive non-maskable interrupt request. An interrupt handler reads the flag to learn whether the oscillator caused the interrupt. The power-up-clear reset puts the primary oscillator in low-frequency mode and switches the secondary off. With a secondary present, the reset by itself therefore raises the flag.

Top module: `osc_fault_nmi`

## Requirements
- R1: After power-up clear: high-frequency mode is 0, the primary off bit is 0, the secondary enable is 0, the interrupt enable is 0 and the interrupt request is 0. When the secondary oscillator is present, the fault flag reads 1 within two cycles because the secondary is switched off.
- R2: An oscillator counts as running while its synchronised clock has shown an edge within the last TIMEOUT_CYC (default 32) system clock cycles. It counts as not running from reset until its first edge.
- R3: With high-frequency mode set to 1, a primary oscillator that is not running sets the fault flag. This includes an oscillator that stops after it has been running.
- R4: With high-frequency mode set to 0, the primary oscillator never causes a fault, whether or not it toggles.
- R5: Setting the primary off bit to 1 while high-frequency mode is 1 sets the fault flag, even while the oscillator toggles.
- R6: When present, the secondary oscillator causes a fault when its enable is 0, or when its enable is 1 and it is not running.
- R7: The flag is sticky. Writing 0 through the flag write port clears it. Writing 1 has no effect. If the fault condition is still present when 0 is written, the flag stays at 1.
- R8: The interrupt request is a level equal to the flag AND the interrupt enable.
- R9: The flag is set when either oscillator is faulty, and a clear only succeeds once neither is faulty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| puc_rst_n | input | 1 | Power-up clear, asynchronous assert, active low |
| osc_clk_i | input | 2 | Raw oscillator clocks, bit 0 primary, bit 1 secondary |
| ctl_we | input | 1 | Write strobe for the oscillator configuration |
| ctl_hf_mode | input | 1 | Primary high-frequency mode value to write |
| ctl_pri_off | input | 1 | Primary off value to write |
| ctl_sec_en | input | 1 | Secondary enable value to write |
| ie_we | input | 1 | Write strobe for the fault interrupt enable |
| ie_wdata | input | 1 | Interrupt enable value to write |
| flag_we | input | 1 | Write strobe for the fault flag |
| flag_wdata | input | 1 | Flag write value; 0 clears, 1 is ignored |
| flag_o | output | 1 | Fault flag readback |
| ie_o | output | 1 | Interrupt enable readback |
| hf_mode_o | output | 1 | High-frequency mode readback |
| pri_off_o | output | 1 | Primary off readback |
| sec_en_o | output | 1 | Secondary enable readback |
| nmi_req_o | output | 1 | Non-maskable interrupt request (level) |

## Verification
The assertions check several rules on every cycle. A fault present in one cycle must leave the flag set in the next. The flag may fall only after a write of 0. A detected edge must mark its oscillator as running, and an oscillator may drop out of the running state only in a cycle without an edge. The directed scenarios cover behaviour that depends on the oscillator waveform over time: how long the timeout window lasts, how mode settings mask a stopped primary, the fault the reset itself provokes, and how the two fault sources combine as seen through the flag and the interrupt pin.

// File: rtl/osc_fault_pkg.sv
package osc_fault_pkg;

  typedef struct packed {
    logic hf_mode;
    logic pri_off;
    logic sec_en;
    logic fault_ie;
  } osc_ctl_t;

  localparam osc_ctl_t CTL_PUC_VALUE = '{hf_mode: 1'b0, pri_off: 1'b0,
                                         sec_en: 1'b0, fault_ie: 1'b0};

  localparam int unsigned OSC_SLOTS = 2;

endpackage

// File: rtl/osc_activity_mon.sv
module osc_activity_mon #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_raw_i,
  output logic running_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [SYNC_STAGES:0] sync_q, sync_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 edge_seen;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-1:0], osc_raw_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign edge_seen = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  always_comb begin
    cnt_d = cnt_q;
    if (edge_seen)          cnt_d = '0;
    else if (cnt_q < LIMIT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LIMIT;
    else        cnt_q <= cnt_d;
  end

  assign running_o = (cnt_q < LIMIT);

  AST_EDGE_MARKS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> running_o); // R2

  AST_STOP_ONLY_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running_o) |-> !$past(edge_seen)); // R2

endmodule

// File: rtl/osc_ctl_regs.sv
module osc_ctl_regs
  import osc_fault_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ctl_we,
  input  logic     hf_mode_w,
  input  logic     pri_off_w,
  input  logic     sec_en_w,
  input  logic     ie_we,
  input  logic     ie_w,
  output osc_ctl_t ctl_o
);
  osc_ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) begin
      ctl_d.hf_mode = hf_mode_w;
      ctl_d.pri_off = pri_off_w;
      ctl_d.sec_en  = sec_en_w;
    end
    if (ie_we) ctl_d.fault_ie = ie_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_PUC_VALUE;
    else        ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;

  AST_MODE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_o.hf_mode)); // R4

endmodule

// File: rtl/osc_fault_flag.sv
module osc_fault_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic flag_we,
  input  logic flag_wdata,
  output logic flag_o
);
  logic flag_q, flag_d, sw_clear;

  assign sw_clear = flag_we & ~flag_wdata;

  always_comb begin
    flag_d = flag_q;
    if (sw_clear) flag_d = 1'b0;
    if (fault_i)  flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_FAULT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> flag_o); // R7

  AST_FLAG_FALLS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> $past(flag_we && !flag_wdata)); // R7

endmodule

// File: rtl/osc_fault_nmi.sv
module osc_fault_nmi
  import osc_fault_pkg::*;
#(
  parameter bit          HAS_SECONDARY = 1'b1,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned TIMEOUT_CYC   = 32
) (
  input  logic       clk,
  input  logic       puc_rst_n,
  input  logic [1:0] osc_clk_i,
  input  logic       ctl_we,
  input  logic       ctl_hf_mode,
  input  logic       ctl_pri_off,
  input  logic       ctl_sec_en,
  input  logic       ie_we,
  input  logic       ie_wdata,
  input  logic       flag_we,
  input  logic       flag_wdata,
  output logic       flag_o,
  output logic       ie_o,
  output logic       hf_mode_o,
  output logic       pri_off_o,
  output logic       sec_en_o,
  output logic       nmi_req_o
);
  logic [OSC_SLOTS-1:0] running;
  osc_ctl_t             ctl;
  logic                 pri_fault, sec_fault, fault_any;

  for (genvar g = 0; g < OSC_SLOTS; g++) begin : g_mon
    osc_activity_mon #(
      .SYNC_STAGES (SYNC_STAGES),
      .TIMEOUT_CYC (TIMEOUT_CYC)
    ) mon_i (
      .clk       (clk),
      .rst_n     (puc_rst_n),
      .osc_raw_i (osc_clk_i[g]),
      .running_o (running[g])
    );
  end

  osc_ctl_regs ctl_i (
    .clk       (clk),
    .rst_n     (puc_rst_n),
    .ctl_we    (ctl_we),
    .hf_mode_w (ctl_hf_mode),
    .pri_off_w (ctl_pri_off),
    .sec_en_w  (ctl_sec_en),
    .ie_we     (ie_we),
    .ie_w      (ie_wdata),
    .ctl_o     (ctl)
  );

  always_comb begin
    pri_fault = ctl.hf_mode & (ctl.pri_off | ~running[0]);
    sec_fault = HAS_SECONDARY & (~ctl.sec_en | ~running[1]);
    fault_any = pri_fault | sec_fault;
  end

  osc_fault_flag flag_i (
    .clk        (clk),
    .rst_n      (puc_rst_n),
    .fault_i    (fault_any),
    .flag_we    (flag_we),
    .flag_wdata (flag_wdata),
    .flag_o     (flag_o)
  );

  assign ie_o      = ctl.fault_ie;
  assign hf_mode_o = ctl.hf_mode;
  assign pri_off_o = ctl.pri_off;
  assign sec_en_o  = ctl.sec_en;
  assign nmi_req_o = flag_o & ctl.fault_ie;

  AST_LF_PRIMARY_SILENT: assert property (@(posedge clk) disable iff (!puc_rst_n)
    (!hf_mode_o && (sec_en_o || !HAS_SECONDARY) && running[1] && !flag_o)
      |=> !flag_o || $past(!hf_mode_o && !running[1])); // R4

  AST_FLAG_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!puc_rst_n)
    $rose(flag_o) |-> $past(fault_any)); // R9

endmodule

// File: tb/osc_fault_nmi_tb_top.sv
`timescale 1ns/1ps
module osc_fault_nmi_tb_top;
  logic       clk = 1'b0;
  logic       puc_rst_n;
  logic [1:0] osc_clk_i;
  logic       ctl_we, ctl_hf_mode, ctl_pri_off, ctl_sec_en;
  logic       ie_we, ie_wdata, flag_we, flag_wdata;
  logic       flag_o, ie_o, hf_mode_o, pri_off_o, sec_en_o, nmi_req_o;
  logic       run0, run1;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  initial begin
    osc_clk_i[0] = 1'b0;
    forever begin
      #11;
      if (run0) osc_clk_i[0] = ~osc_clk_i[0];
    end
  end

  initial begin
    osc_clk_i[1] = 1'b0;
    forever begin
      #17;
      if (run1) osc_clk_i[1] = ~osc_clk_i[1];
    end
  end

  osc_fault_nmi dut_i (
    .clk(clk), .puc_rst_n(puc_rst_n), .osc_clk_i(osc_clk_i),
    .ctl_we(ctl_we), .ctl_hf_mode(ctl_hf_mode), .ctl_pri_off(ctl_pri_off),
    .ctl_sec_en(ctl_sec_en), .ie_we(ie_we), .ie_wdata(ie_wdata),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .flag_o(flag_o), .ie_o(ie_o),
    .hf_mode_o(hf_mode_o), .pri_off_o(pri_off_o), .sec_en_o(sec_en_o),
    .nmi_req_o(nmi_req_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctl(input logic hf, input logic off, input logic sen);
    ctl_hf_mode = hf; ctl_pri_off = off; ctl_sec_en = sen; ctl_we = 1'b1;
    cyc(1);
    ctl_we = 1'b0;
  endtask

  task automatic write_flag(input logic v);
    flag_wdata = v; flag_we = 1'b1;
    cyc(1);
    flag_we = 1'b0;
    cyc(1);
  endtask

  task automatic write_ie(input logic v);
    ie_wdata = v; ie_we = 1'b1;
    cyc(1);
    ie_we = 1'b0;
  endtask

  task automatic t_reset;
    cyc(3);
    chk("R1 hf_mode", hf_mode_o, 1'b0);
    chk("R1 pri_off", pri_off_o, 1'b0);
    chk("R1 sec_en", sec_en_o, 1'b0);
    chk("R1 ie", ie_o, 1'b0);
    chk("R1 nmi", nmi_req_o, 1'b0);
    chk("R1 flag from secondary off", flag_o, 1'b1);
  endtask

  task automatic t_secondary_ok;
    run1 = 1'b1;
    write_ctl(1'b0, 1'b0, 1'b1);
    cyc(10);
    write_flag(1'b0);
    chk("R6 enabled running secondary clean", flag_o, 1'b0);
    write_flag(1'b1);
    chk("R7 write 1 ignored", flag_o, 1'b0);
  endtask

  task automatic t_lf_mode;
    run0 = 1'b0;
    cyc(50);
    chk("R4 LF stopped no fault", flag_o, 1'b0);
    run0 = 1'b1;
    cyc(20);
    chk("R4 LF running no fault", flag_o, 1'b0);
    run0 = 1'b0;
    cyc(50);
  endtask

  task automatic t_hf_stopped;
    write_ctl(1'b1, 1'b0, 1'b1);
    cyc(2);
    chk("R3 HF stopped primary", flag_o, 1'b1);
    write_flag(1'b0);
    chk("R7 clear while fault present", flag_o, 1'b1);
  endtask

  task automatic t_timeout;
    run0 = 1'b1;
    cyc(20);
    write_flag(1'b0);
    chk("R2 HF running primary clean", flag_o, 1'b0);
    run0 = 1'b0;
    cyc(20);
    chk("R2 inside window no fault", flag_o, 1'b0);
    cyc(30);
    chk("R3 primary stopped after running", flag_o, 1'b1);
    run0 = 1'b1;
    cyc(10);
    write_flag(1'b0);
    chk("R2 restart clears condition", flag_o, 1'b0);
  endtask

  task automatic t_pri_off;
    write_ctl(1'b1, 1'b1, 1'b1);
    cyc(2);
    chk("R5 primary switched off in HF", flag_o, 1'b1);
    write_ctl(1'b1, 1'b0, 1'b1);
    write_flag(1'b0);
    chk("R5 back on clean", flag_o, 1'b0);
  endtask

  task automatic t_nmi_and_or;
    write_ie(1'b1);
    cyc(1);
    chk("R8 nmi low with flag low", nmi_req_o, 1'b0);
    run1 = 1'b0;
    cyc(50);
    chk("R6 secondary stopped", flag_o, 1'b1);
    chk("R8 nmi with flag and ie", nmi_req_o, 1'b1);
    run0 = 1'b0;
    cyc(50);
    run1 = 1'b1;
    cyc(10);
    write_flag(1'b0);
    chk("R9 primary alone keeps flag", flag_o, 1'b1);
    run0 = 1'b1;
    cyc(10);
    write_flag(1'b0);
    chk("R9 both healthy clears", flag_o, 1'b0);
    write_ctl(1'b1, 1'b0, 1'b0);
    cyc(2);
    chk("R6 secondary disabled", flag_o, 1'b1);
    write_ie(1'b0);
    cyc(1);
    chk("R8 nmi follows ie", nmi_req_o, 1'b0);
  endtask

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    puc_rst_n = 1'b0;
    run0 = 1'b0; run1 = 1'b0;
    ctl_we = 1'b0; ctl_hf_mode = 1'b0; ctl_pri_off = 1'b0; ctl_sec_en = 1'b0;
    ie_we = 1'b0; ie_wdata = 1'b0; flag_we = 1'b0; flag_wdata = 1'b0;
    cyc(4);
    puc_rst_n = 1'b1;
    t_reset();
    t_secondary_ok();
    t_lf_mode();
    t_hf_stopped();
    t_timeout();
    t_pri_off();
    t_nmi_and_or();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule